// File: doc/BRIEF.md
# Descriptor Ring Channel Controller

This block steps one DMA channel through a circular list of buffer descriptors kept in memory. Software places N data descriptors in memory, followed by one closing link descriptor whose next-pointer leads back to the first entry. It then tells the channel how far to go by writing a free-running cumulative write count. The channel fetches one descriptor at a time from its current position and keeps going until its own read count equals the write count. The read count counts link slots as well, so the ring index of any count is that count modulo N+1.

Each fetch is a single 8-word burst read on a request/response memory port. A data descriptor starts a transfer through a pulse to an external mover and is complete one cycle after that mover reports done. A link descriptor starts no transfer: it only moves the fetch pointer back to the ring base. Status goes back to software through a run flag, a sticky abort flag, the read count, and four write-one-to-clear interrupt flags combined with an enable mask into one interrupt line. An init strobe returns the channel to its starting state.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset or an `initReq` pulse, `rdCnt` and the write count are 0, `running`, `aborted` and all `intStatus` bits are 0, and the next fetch address is `ringBase` with its low 5 bits cleared.
- R2: Each descriptor is fetched with one memory request whose address is the current descriptor pointer, and the 8 response beats are taken in order. After a data descriptor completes, the pointer advances by 32 bytes.
- R3: A write count accepted while the channel is idle and not aborted starts fetching only if it differs from `rdCnt`. Fetching stops when `rdCnt` equals the write count. A write equal to `rdCnt` causes no fetch.
- R4: Bits 31:29 of descriptor word 0 hold the type: 1 is data and 3 is link. For a link, the next fetch address is the low ADDR_W bits of {word3, word2} with the low 5 bits cleared. The link increments `rdCnt` and produces no `xferStart`.
- R5: A data descriptor produces exactly one single-cycle `xferStart`. It completes in the cycle after `xferDone`, and `rdCnt` then increments by one.
- R6: When a completed data descriptor has bit 28 of word 0 set, `intStatus[1]` (finish-flag done) is set.
- R7: When `rdCnt` reaches the write count, `intStatus[0]` (done) is set. This holds also when the last slot is a link.
- R8: `running` is high from the acceptance of a write count that differs from `rdCnt` until the write count is reached. A write count presented while `running` or `aborted` is high is ignored.
- R9: `xferErr` during a transfer, or a type other than 1 or 3, sets `intStatus[3]` and `aborted`. `aborted` stays high, and no fetch or transfer happens, until `initReq`.
- R10: A `stsFull` pulse sets `intStatus[2]`.
- R11: A 1 in `intClr` clears the matching `intStatus` bit unless that bit is set in the same cycle (setting wins). `irq` is the OR of `intStatus & intEn`.
- R12: `memReqValid` stays high with an unchanged address until `memReqReady` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ringBase | input | ADDR_W | Byte address of ring entry 0, taken on reset and init |
| initReq | input | 1 | Init strobe: resets counts, flags and pointer |
| wrCntWe | input | 1 | Write strobe for the cumulative write count |
| wrCntData | input | CNT_W | New write count |
| rdCnt | output | CNT_W | Number of slots processed since init |
| running | output | 1 | Descriptors pending |
| aborted | output | 1 | Channel stopped on an error |
| intEn | input | 4 | Interrupt enable mask |
| intClr | input | 4 | Write-one-to-clear strobes for intStatus |
| stsFull | input | 1 | Status FIFO full event |
| intStatus | output | 4 | {err, stFull, finishFlagDone, done} |
| irq | output | 1 | Masked interrupt |
| memReqValid | output | 1 | Descriptor fetch request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Fetch byte address |
| memRspValid | input | 1 | Response beat valid |
| memRspData | input | 32 | Response beat data |
| xferStart | output | 1 | Start pulse for the data mover |
| xferDone | input | 1 | Data mover finished the descriptor |
| xferErr | input | 1 | Data mover failed |

## Verification
The embedded assertions check on every cycle the rules that must hold at each edge. The read count only stays the same or steps by one between inits. Interrupt bits fall only on a clear strobe or init. Abort is sticky. A stalled request is held. While the channel is aborted, no request or start pulse appears. The idle channel always has matching counts. Only the bench scenarios can show that the fetch addresses come in the right order around the ring, including the masked link pointer and a link in the last slot. They also show that ignored writes leave the count unchanged, that the finish flag and done flags rise for the right descriptors, and that init recovers an aborted channel.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int DESC_WORDS = 8;
  localparam int WSEL_W     = $clog2(DESC_WORDS);
  localparam int INT_W      = 4;
  localparam int INT_DONE   = 0;
  localparam int INT_IOF    = 1;
  localparam int INT_STFULL = 2;
  localparam int INT_ERR    = 3;
  localparam logic [2:0] TYPE_DATA = 3'd1;
  localparam logic [2:0] TYPE_LINK = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RSP, ST_DEC, ST_XWAIT, ST_CMPL, ST_ABT
  } chanState_t;

  typedef struct packed {
    logic              ldWord;
    logic [WSEL_W-1:0] wordSel;
    logic              advPtr;
    logic              linkJump;
    logic              setDone;
    logic              setIof;
    logic              setErr;
    logic              setAbort;
  } ctlStrobes_t;
endpackage

// File: rtl/ring_dma_dp.sv
module ring_dma_dp
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              initReq,
  input  logic              wrCntWe,
  input  logic [CNT_W-1:0]  wrCntData,
  input  logic              runningIn,
  input  ctlStrobes_t       stb,
  input  logic [31:0]       memRspData,
  input  logic              stsFull,
  input  logic [INT_W-1:0]  intClr,
  input  logic [INT_W-1:0]  intEn,
  output logic [ADDR_W-1:0] descPtr,
  output logic [CNT_W-1:0]  rdCnt,
  output logic              aborted,
  output logic [INT_W-1:0]  intStatus,
  output logic              irq,
  output logic [2:0]        descType,
  output logic              iofFlag,
  output logic              cntEq,
  output logic              lastSlot
);
  localparam int DESC_BYTES = DESC_WORDS * 4;
  localparam int ALIGN_BITS = $clog2(DESC_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  logic [CNT_W-1:0]  wrCnt;
  logic [31:0]       word0, word2, word3;
  logic [63:0]       linkRaw;
  logic [ADDR_W-1:0] linkNext;
  logic [INT_W-1:0]  intSet;
  logic              wrAccept;
  logic              unusedBits;

  assign linkRaw    = {word3, word2};
  assign linkNext   = linkRaw[ADDR_W-1:0] & ~ALIGN_MASK;
  assign unusedBits = ^{linkRaw, word0[27:0]};
  assign descType   = word0[31:29];
  assign iofFlag    = word0[28];
  assign cntEq      = (rdCnt == wrCnt);
  assign lastSlot   = ((rdCnt + 1'b1) == wrCnt);
  assign wrAccept   = wrCntWe && !runningIn && !aborted;

  // descriptor word capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0 <= '0;
      word2 <= '0;
      word3 <= '0;
    end else if (stb.ldWord) begin
      if (stb.wordSel == WSEL_W'(0)) word0 <= memRspData;
      if (stb.wordSel == WSEL_W'(2)) word2 <= memRspData;
      if (stb.wordSel == WSEL_W'(3)) word3 <= memRspData;
    end
  end

  // pointer and counters
  always_ff @(posedge clk) begin
    if (!rstN || initReq) begin
      descPtr <= ringBase & ~ALIGN_MASK;
      rdCnt   <= '0;
      wrCnt   <= '0;
      aborted <= 1'b0;
    end else begin
      if (wrAccept)     wrCnt   <= wrCntData;
      if (stb.advPtr)   descPtr <= descPtr + ADDR_W'(DESC_BYTES);
      if (stb.linkJump) descPtr <= linkNext;
      if (stb.advPtr || stb.linkJump) rdCnt <= rdCnt + 1'b1;
      if (stb.setAbort) aborted <= 1'b1;
    end
  end

  // interrupt flags, setting wins over clearing
  always_comb begin
    intSet             = '0;
    intSet[INT_DONE]   = stb.setDone;
    intSet[INT_IOF]    = stb.setIof;
    intSet[INT_STFULL] = stsFull;
    intSet[INT_ERR]    = stb.setErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN || initReq) intStatus <= '0;
    else                  intStatus <= (intStatus & ~intClr) | intSet;
  end

  assign irq = |(intStatus & intEn);

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (rdCnt == '0) && (intStatus == '0) && !aborted && cntEq);

  // R9
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    aborted && !initReq |=> aborted);

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initReq |=> (rdCnt == $past(rdCnt)) || (rdCnt == $past(rdCnt) + 1'b1));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    runningIn && !initReq |=> $stable(wrCnt));

  // R12
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advPtr && !stb.linkJump && !initReq |=> $stable(descPtr));

  generate
    for (genvar b = 0; b < INT_W; b++) begin : g_w1c
      // R11
      w1c_only_chk: assert property (@(posedge clk) disable iff (!rstN)
        $fell(intStatus[b]) |-> $past(intClr[b] || initReq));
    end
  endgenerate
endmodule

// File: rtl/ring_dma_ctl.sv
module ring_dma_ctl
  import ring_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  logic        cntEq,
  input  logic        lastSlot,
  input  logic [2:0]  descType,
  input  logic        iofFlag,
  input  logic        abortedIn,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        xferDone,
  input  logic        xferErr,
  output logic        memReqValid,
  output logic        xferStart,
  output logic        running,
  output ctlStrobes_t stb
);
  chanState_t        state, nextState;
  logic [WSEL_W-1:0] beat;

  always_ff @(posedge clk) begin
    if (!rstN || initReq) state <= ST_IDLE;
    else                  state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || initReq || state == ST_REQ) beat <= '0;
    else if (state == ST_RSP && memRspValid) beat <= beat + 1'b1;
  end

  always_comb begin
    nextState   = state;
    stb         = '0;
    stb.wordSel = beat;
    memReqValid = 1'b0;
    xferStart   = 1'b0;
    unique case (state)
      ST_IDLE:  if (!cntEq) nextState = ST_REQ;
      ST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_RSP;
      end
      ST_RSP: if (memRspValid) begin
        stb.ldWord = 1'b1;
        if (beat == WSEL_W'(DESC_WORDS - 1)) nextState = ST_DEC;
      end
      ST_DEC: begin
        if (descType == TYPE_DATA) begin
          xferStart = 1'b1;
          nextState = ST_XWAIT;
        end else if (descType == TYPE_LINK) begin
          stb.linkJump = 1'b1;
          stb.setDone  = lastSlot;
          nextState    = lastSlot ? ST_IDLE : ST_REQ;
        end else begin
          stb.setErr   = 1'b1;
          stb.setAbort = 1'b1;
          nextState    = ST_ABT;
        end
      end
      ST_XWAIT: begin
        if (xferErr) begin
          stb.setErr   = 1'b1;
          stb.setAbort = 1'b1;
          nextState    = ST_ABT;
        end else if (xferDone) begin
          nextState = ST_CMPL;
        end
      end
      ST_CMPL: begin
        stb.advPtr  = 1'b1;
        stb.setIof  = iofFlag;
        stb.setDone = lastSlot;
        nextState   = lastSlot ? ST_IDLE : ST_REQ;
      end
      ST_ABT:   nextState = ST_ABT;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign running = (state != ST_IDLE && state != ST_ABT) || (state == ST_IDLE && !cntEq);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady && !initReq |=> memReqValid);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortedIn |-> !memReqValid && !xferStart);

  // R8
  idle_eq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running && !abortedIn |-> cntEq);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              initReq,
  input  logic              wrCntWe,
  input  logic [CNT_W-1:0]  wrCntData,
  output logic [CNT_W-1:0]  rdCnt,
  output logic              running,
  output logic              aborted,
  input  logic [3:0]        intEn,
  input  logic [3:0]        intClr,
  input  logic              stsFull,
  output logic [3:0]        intStatus,
  output logic              irq,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              xferStart,
  input  logic              xferDone,
  input  logic              xferErr
);
  ctlStrobes_t stb;
  logic [2:0]  descType;
  logic        iofFlag, cntEq, lastSlot;

  ring_dma_ctl u_ctl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .cntEq(cntEq), .lastSlot(lastSlot),
    .descType(descType), .iofFlag(iofFlag), .abortedIn(aborted),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .xferDone(xferDone), .xferErr(xferErr), .memReqValid(memReqValid),
    .xferStart(xferStart), .running(running), .stb(stb)
  );

  ring_dma_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .initReq(initReq),
    .wrCntWe(wrCntWe), .wrCntData(wrCntData), .runningIn(running), .stb(stb),
    .memRspData(memRspData), .stsFull(stsFull), .intClr(intClr), .intEn(intEn),
    .descPtr(memReqAddr), .rdCnt(rdCnt), .aborted(aborted), .intStatus(intStatus),
    .irq(irq), .descType(descType), .iofFlag(iofFlag), .cntEq(cntEq), .lastSlot(lastSlot)
  );
endmodule

// File: tb/ring_dma_chan_test.sv
module ring_dma_chan_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ringBase = 32'h0000_010C;
  logic        initReq = 1'b0, wrCntWe = 1'b0;
  logic [15:0] wrCntData = '0;
  logic [15:0] rdCnt;
  logic        running, aborted, irq, memReqValid, xferStart;
  logic [3:0]  intEn = '0, intClr = '0, intStatus;
  logic        stsFull = 1'b0;
  logic        memReqReady = 1'b1, memRspValid = 1'b0, xferDone = 1'b0, xferErr = 1'b0;
  logic [31:0] memReqAddr, memRspData = '0;

  int nChecks = 0, nBad = 0, startCount = 0, cyc = 0;
  logic [31:0] mem [0:127];
  logic [31:0] expQ [$];
  int  rspCnt = 0, rspWord = 0, xCnt = 0;
  bit  stallMode = 0, errInject = 0;

  ring_dma_chan uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder, scoreboard monitor and data mover stub
  always @(negedge clk) begin
    cyc++;
    xferDone = 1'b0;
    xferErr  = 1'b0;
    if (rspCnt > 0) begin
      memRspValid = 1'b1;
      memRspData  = mem[rspWord];
      rspWord++;
      rspCnt--;
    end else memRspValid = 1'b0;
    memReqReady = stallMode ? (cyc % 3 != 0) : 1'b1;
    if (rstN && memReqValid && memReqReady) begin
      if (expQ.size() == 0) chk(0, "R3 unexpected fetch", memReqAddr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(memReqAddr == e, "R2 fetch address", memReqAddr, e);
      end
      rspWord = int'(memReqAddr[8:2]);
      rspCnt  = 8;
    end
    if (xCnt > 0) begin
      xCnt--;
      if (xCnt == 0) begin
        if (errInject) xferErr = 1'b1;
        else           xferDone = 1'b1;
      end
    end
    if (rstN && xferStart) begin
      xCnt = 3;
      startCount++;
    end
  end

  task automatic pulseInit();
    @(negedge clk); initReq = 1'b1;
    @(negedge clk); initReq = 1'b0;
  endtask

  task automatic writeCnt(input logic [15:0] v);
    @(negedge clk); wrCntWe = 1'b1; wrCntData = v;
    @(negedge clk); wrCntWe = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while ((running && !aborted) && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[64] = 32'h2000_0000;                 // slot0 data
    mem[72] = 32'h3000_0000;                 // slot1 data, finish flag
    mem[80] = 32'h2000_0000;                 // slot2 data
    mem[88] = 32'h6000_0000;                 // slot3 link
    mem[90] = 32'h0000_011F;                 // next pointer low word, unaligned
    mem[91] = 32'hDEAD_BEEF;                 // next pointer high word
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdCnt == 0, "R1 rdCnt", rdCnt, 0);
    chk(!running && !aborted, "R1 run/abort", {running, aborted}, 0);
    chk(intStatus == 0 && !irq, "R1 flags", {irq, intStatus}, 0);

    // R2 R6 R7 first two slots; base 0x10C masks to 0x100
    expQ.push_back(32'h100); expQ.push_back(32'h120);
    writeCnt(2);
    chk(running == 1'b1, "R8 running after write", running, 1);
    waitIdle();
    chk(rdCnt == 2, "R3 rdCnt reaches write count", rdCnt, 2);
    chk(startCount == 2, "R5 start pulses", startCount, 2);
    chk(intStatus == 4'b0011, "R6 R7 done and finish flag", intStatus, 4'b0011);
    chk(irq == 1'b0, "R11 masked irq", irq, 0);
    @(negedge clk); intEn = 4'b0001;
    @(negedge clk);
    chk(irq == 1'b1, "R11 enabled irq", irq, 1);
    intClr = 4'b0011;
    @(negedge clk); intClr = 4'b0000;
    @(negedge clk);
    chk(intStatus == 0 && !irq, "R11 write-one-clear", {irq, intStatus}, 0);

    // R3 equal write count starts nothing
    writeCnt(2);
    repeat (10) @(negedge clk);
    chk(rdCnt == 2 && !running, "R3 equal count idle", rdCnt, 2);
    chk(intStatus == 0, "R3 no done on equal count", intStatus, 0);

    // R4 R12 across the link with stalls; R8 write during run ignored
    stallMode = 1;
    expQ.push_back(32'h140); expQ.push_back(32'h160);
    expQ.push_back(32'h100); expQ.push_back(32'h120);
    writeCnt(6);
    repeat (4) @(negedge clk);
    chk(running == 1'b1, "R8 running mid-run", running, 1);
    writeCnt(9);
    waitIdle();
    repeat (20) @(negedge clk);
    chk(rdCnt == 6, "R8 ignored write during run", rdCnt, 6);
    chk(expQ.size() == 0, "R4 all fetches seen", expQ.size(), 0);
    chk(startCount == 5, "R4 link starts no transfer", startCount, 5);
    chk(intStatus[0] == 1'b1, "R7 done", intStatus, 4'b0011);
    stallMode = 0;
    intClr = 4'b1111; @(negedge clk); intClr = 4'b0000;

    // R7 link in the last slot
    expQ.push_back(32'h140); expQ.push_back(32'h160);
    writeCnt(8);
    waitIdle();
    chk(rdCnt == 8, "R7 link last rdCnt", rdCnt, 8);
    chk(intStatus == 4'b0001, "R7 done on link", intStatus, 4'b0001);
    chk(startCount == 6, "R5 one start", startCount, 6);

    // R10 R11 status-full, set wins over clear
    @(negedge clk); stsFull = 1'b1; intClr = 4'b0100;
    @(negedge clk); stsFull = 1'b0; intClr = 4'b0000;
    @(negedge clk);
    chk(intStatus[2] == 1'b1, "R10 R11 stFull set wins", intStatus, 4'b0101);
    intClr = 4'b1111; @(negedge clk); intClr = 4'b0000;
    @(negedge clk);

    // R9 transfer error aborts; later write ignored; init recovers
    errInject = 1;
    expQ.push_back(32'h100);
    writeCnt(9);
    repeat (40) @(negedge clk);
    chk(aborted == 1'b1, "R9 aborted", aborted, 1);
    chk(intStatus == 4'b1000, "R9 err flag", intStatus, 4'b1000);
    chk(!running && rdCnt == 8, "R9 halted", rdCnt, 8);
    writeCnt(12);
    repeat (30) @(negedge clk);
    chk(rdCnt == 8 && aborted, "R9 write ignored while aborted", rdCnt, 8);
    errInject = 0;
    pulseInit();
    @(negedge clk);
    chk(rdCnt == 0 && !aborted && intStatus == 0, "R1 init clears", {aborted, intStatus, rdCnt}, 0);

    // R9 bad descriptor type
    mem[64] = 32'hA000_0000;
    expQ.push_back(32'h100);
    writeCnt(1);
    repeat (30) @(negedge clk);
    chk(aborted && intStatus[3], "R9 bad type aborts", {aborted, intStatus}, 5'b11000);
    chk(rdCnt == 0 && startCount == 7, "R9 no transfer on bad type", startCount, 7);
    pulseInit();
    @(negedge clk);
    chk(!aborted && !running, "R1 init after bad type", aborted, 0);

    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule